// File: doc/BRIEF.md
# Bus-Master Memory Command Selector

This block decides, for every burst a DMA engine is about to start, which bus memory command goes out on the command/byte-enable lines during the address phase. A requester presents the kind of transfer, how many bytes remain in the current buffer fragment, the room or data held in the relevant FIFO, and whether the opposite DMA engine is also waiting for the bus. The block answers with a four-bit command code one clock later.

Descriptor traffic always uses the plain commands. Data bursts move up to the line-oriented commands only when both the fragment and the FIFO can cover at least one whole cache line, and the other engine is not waiting. Under that rule a long burst never holds off a competing request. Write-and-invalidate is further gated by two separate control bits. One is an enable in configuration space. The other is a disable in the DMA control register, which clears on reset.

Top module: `bm_cmd_select`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `cmd_valid` is 0 and `cmd_code` is 4'b0000.
- R2: `cmd_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was sampled high, and 0 in every other cycle.
- R3: A request with `req_kind` = 2'd0 (descriptor fetch) yields Memory Read, 4'b0110, whatever the other inputs are.
- R4: A request with `req_kind` = 2'd1 (descriptor write-back) yields Memory Write, 4'b0111, whatever the other inputs are.
- R5: A request with `req_kind` = 2'd2 (transmit data read) yields Memory Read Multiple, 4'b1100, when `frag_left` >= LINE_BYTES, `tx_free` >= LINE_BYTES and `peer_busy` = 0. Otherwise it yields Memory Read, 4'b0110.
- R6: A request with `req_kind` = 2'd3 (receive data write) yields Memory Write and Invalidate, 4'b1111, when `frag_left` >= LINE_BYTES, `rx_level` >= LINE_BYTES, `peer_busy` = 0 and invalidate writes are permitted. Otherwise it yields Memory Write, 4'b0111.
- R7: Invalidate writes are permitted only when `cfg_mwi_en` = 1 and `dma_mwi_dis` = 0. With either bit in the other state, no request produces 4'b1111.
- R8: In a cycle that follows a clock with no request, `cmd_code` keeps the value it had before that clock.
- R9: The line comparisons include equality. A value of exactly LINE_BYTES (default 32) qualifies, and LINE_BYTES-1 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A burst is starting and needs a command |
| req_kind | input | 2 | 0 descriptor fetch, 1 descriptor write-back, 2 transmit data read, 3 receive data write |
| frag_left | input | FRAG_W (16) | Bytes remaining in the current fragment |
| tx_free | input | FIFO_W (12) | Free bytes in the transmit FIFO |
| rx_level | input | FIFO_W (12) | Bytes held in the receive FIFO |
| peer_busy | input | 1 | The opposite DMA engine has a bus request pending |
| cfg_mwi_en | input | 1 | Configuration-space enable for invalidate writes |
| dma_mwi_dis | input | 1 | DMA-control disable for invalidate writes |
| cmd_valid | output | 1 | `cmd_code` belongs to the request of the previous cycle |
| cmd_code | output | 4 | Bus command code |

## Verification
The bench sweeps the fragment and FIFO values across LINE_BYTES-1 and LINE_BYTES. A design that used a strict comparison would drop exact-line bursts to the plain commands. A design that compared against one byte less would promote short bursts. The bench holds everything else favourable and toggles each invalidate control bit alone. A design that tested only one of the two bits, or read the disable bit with the wrong polarity, would issue 4'b1111 when it is forbidden. Descriptor requests are presented with every data condition met, to catch a selector that lets transfer kinds share a decision path. Idle cycles are placed between requests, so a design that clears or changes the code without a request shows up as a mismatch.

// File: rtl/bm_cmd_pkg.sv
package bm_cmd_pkg;

    typedef enum logic [1:0] {
        XK_DESC_FETCH = 2'd0,
        XK_DESC_WB    = 2'd1,
        XK_TX_READ    = 2'd2,
        XK_RX_WRITE   = 2'd3
    } xfer_kind_e;

    typedef enum logic [3:0] {
        CMD_NONE = 4'b0000,
        CMD_MR   = 4'b0110,
        CMD_MRM  = 4'b1100,
        CMD_MW   = 4'b0111,
        CMD_MWI  = 4'b1111
    } bus_cmd_e;

    typedef struct packed {
        logic     valid;
        bus_cmd_e code;
    } cmd_out_t;

    function automatic logic covers_line(input logic [31:0] amount,
                                         input logic [31:0] line_bytes);
        return amount >= line_bytes;
    endfunction

endpackage

// File: rtl/bm_rd_pick.sv
module bm_rd_pick
    import bm_cmd_pkg::*;
#(
    parameter int FRAG_W     = 16,
    parameter int FIFO_W     = 12,
    parameter int LINE_BYTES = 32
) (
    input  logic [FRAG_W-1:0] frag_left,
    input  logic [FIFO_W-1:0] tx_free,
    input  logic              peer_busy,
    output bus_cmd_e          rd_cmd
);
    localparam logic [31:0] LINE32 = 32'(LINE_BYTES);

    logic frag_ok;
    logic room_ok;

    always_comb begin
        frag_ok = covers_line(32'(frag_left), LINE32);
        room_ok = covers_line(32'(tx_free), LINE32);
        rd_cmd  = (frag_ok && room_ok && !peer_busy) ? CMD_MRM : CMD_MR;
    end
endmodule

// File: rtl/bm_wr_pick.sv
module bm_wr_pick
    import bm_cmd_pkg::*;
#(
    parameter int FRAG_W     = 16,
    parameter int FIFO_W     = 12,
    parameter int LINE_BYTES = 32
) (
    input  logic [FRAG_W-1:0] frag_left,
    input  logic [FIFO_W-1:0] rx_level,
    input  logic              peer_busy,
    input  logic              cfg_mwi_en,
    input  logic              dma_mwi_dis,
    output bus_cmd_e          wr_cmd
);
    localparam logic [31:0] LINE32 = 32'(LINE_BYTES);

    logic frag_ok;
    logic data_ok;
    logic inval_allowed;

    always_comb begin
        frag_ok       = covers_line(32'(frag_left), LINE32);
        data_ok       = covers_line(32'(rx_level), LINE32);
        inval_allowed = cfg_mwi_en & ~dma_mwi_dis;
        wr_cmd = (frag_ok && data_ok && !peer_busy && inval_allowed) ? CMD_MWI : CMD_MW;
    end
endmodule

// File: rtl/bm_cmd_reg.sv
module bm_cmd_reg
    import bm_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  bus_cmd_e next_cmd,
    output cmd_out_t out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.valid <= 1'b0;
            out_q.code  <= CMD_NONE;
        end else begin
            out_q.valid <= load;
            if (load) out_q.code <= next_cmd;
        end
    end

    // R2: a strobe follows every request
    p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> out_q.valid);
    // R2: no strobe without a request
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> !out_q.valid);
    // R8: code held across idle cycles
    p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(out_q.code));
endmodule

// File: rtl/bm_cmd_select.sv
module bm_cmd_select
    import bm_cmd_pkg::*;
#(
    parameter int FRAG_W     = 16,
    parameter int FIFO_W     = 12,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [FRAG_W-1:0] frag_left,
    input  logic [FIFO_W-1:0] tx_free,
    input  logic [FIFO_W-1:0] rx_level,
    input  logic              peer_busy,
    input  logic              cfg_mwi_en,
    input  logic              dma_mwi_dis,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code
);
    xfer_kind_e kind;
    bus_cmd_e   rd_cmd;
    bus_cmd_e   wr_cmd;
    bus_cmd_e   sel_cmd;
    cmd_out_t   out_q;

    assign kind = xfer_kind_e'(req_kind);

    bm_rd_pick #(.FRAG_W(FRAG_W), .FIFO_W(FIFO_W), .LINE_BYTES(LINE_BYTES)) u_rd (
        .frag_left (frag_left),
        .tx_free   (tx_free),
        .peer_busy (peer_busy),
        .rd_cmd    (rd_cmd)
    );

    bm_wr_pick #(.FRAG_W(FRAG_W), .FIFO_W(FIFO_W), .LINE_BYTES(LINE_BYTES)) u_wr (
        .frag_left   (frag_left),
        .rx_level    (rx_level),
        .peer_busy   (peer_busy),
        .cfg_mwi_en  (cfg_mwi_en),
        .dma_mwi_dis (dma_mwi_dis),
        .wr_cmd      (wr_cmd)
    );

    always_comb begin
        unique case (kind)
            XK_DESC_FETCH: sel_cmd = CMD_MR;
            XK_DESC_WB:    sel_cmd = CMD_MW;
            XK_TX_READ:    sel_cmd = rd_cmd;
            default:       sel_cmd = wr_cmd;
        endcase
    end

    bm_cmd_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .load     (req_valid),
        .next_cmd (sel_cmd),
        .out_q    (out_q)
    );

    assign cmd_valid = out_q.valid;
    assign cmd_code  = out_q.code;

    // R3: descriptor fetch leaves as plain read
    p_desc_fetch_mr_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0) |=> (cmd_code == 4'b0110));
    // R4: descriptor write-back leaves as plain write
    p_desc_wb_mw_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1) |=> (cmd_code == 4'b0111));
    // R5: read-multiple never issued while the peer waits
    p_mrm_peer_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && peer_busy) |=> (cmd_code != 4'b1100));
    // R7: invalidate writes only with both control bits favourable
    p_mwi_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!cfg_mwi_en || dma_mwi_dis)) |=> (cmd_code != 4'b1111));
endmodule

// File: tb/bm_cmd_select_tb.sv
`timescale 1ns/1ps
module bm_cmd_select_tb;
    localparam int LINE = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] frag_left = '0;
    logic [11:0] tx_free = '0;
    logic [11:0] rx_level = '0;
    logic        peer_busy = 1'b0;
    logic        cfg_mwi_en = 1'b0;
    logic        dma_mwi_dis = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd_code;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bm_cmd_select u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .frag_left(frag_left), .tx_free(tx_free), .rx_level(rx_level),
        .peer_busy(peer_busy), .cfg_mwi_en(cfg_mwi_en), .dma_mwi_dis(dma_mwi_dis),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    // behavioural reference
    int    m_valid = 0;
    int    m_code = 0;
    string m_tag = "R1";

    function automatic int ref_code(int kind, int frag, int free, int lvl,
                                    int peer, int en, int dis);
        if (kind == 0) return 6;
        if (kind == 1) return 7;
        if (kind == 2) return (frag >= LINE && free >= LINE && peer == 0) ? 12 : 6;
        return (frag >= LINE && lvl >= LINE && peer == 0 && en == 1 && dis == 0) ? 15 : 7;
    endfunction

    function automatic string ref_tag(int kind, int en, int dis);
        if (kind == 0) return "R3";
        if (kind == 1) return "R4";
        if (kind == 2) return "R5/R9";
        return (en == 0 || dis == 1) ? "R7" : "R6/R9";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 0; m_code <= 0; m_tag <= "R1";
        end else begin
            m_valid <= int'(req_valid);
            if (req_valid) begin
                m_code <= ref_code(int'(req_kind), int'(frag_left), int'(tx_free),
                                   int'(rx_level), int'(peer_busy),
                                   int'(cfg_mwi_en), int'(dma_mwi_dis));
                m_tag  <= ref_tag(int'(req_kind), int'(cfg_mwi_en), int'(dma_mwi_dis));
            end else if (m_tag == "R1") begin
                m_tag <= "R1";
            end else begin
                m_tag <= "R8";
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (int'(cmd_valid) != m_valid) begin
                mismatched++;
                $display("FAIL %s valid: actual %0d expected %0d",
                         (m_tag == "R1") ? "R1" : "R2", cmd_valid, m_valid);
            end
            compared++;
            if (int'(cmd_code) != m_code) begin
                mismatched++;
                $display("FAIL %s code: actual %b expected %b",
                         m_tag, cmd_code, 4'(m_code));
            end
        end
    end

    task automatic drive(bit v, int k, int f, int t, int l, bit p, bit en, bit dis);
        @(negedge clk);
        req_valid = v; req_kind = 2'(k); frag_left = 16'(f); tx_free = 12'(t);
        rx_level = 12'(l); peer_busy = p; cfg_mwi_en = en; dma_mwi_dis = dis;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        // R3, R4 with every data condition met
        drive(1, 0, 500, 500, 500, 0, 1, 0);
        drive(1, 1, 500, 500, 500, 0, 1, 0);
        // R5, R9 boundaries
        drive(1, 2, LINE, LINE, 0, 0, 0, 0);
        drive(1, 2, LINE-1, LINE, 0, 0, 0, 0);
        drive(1, 2, LINE, LINE-1, 0, 0, 0, 0);
        drive(1, 2, LINE, LINE, 0, 1, 0, 0);
        // R6, R7, R9
        drive(1, 3, LINE, 0, LINE, 0, 1, 0);
        drive(1, 3, LINE, 0, LINE, 0, 1, 1);
        drive(1, 3, LINE, 0, LINE, 0, 0, 0);
        drive(1, 3, LINE, 0, LINE-1, 0, 1, 0);
        drive(1, 3, LINE-1, 0, LINE, 0, 1, 0);
        drive(1, 3, LINE, 0, LINE, 1, 1, 0);
        drive(1, 3, 900, 0, 900, 0, 1, 0);
        // R8 idle hold with inputs moving
        drive(0, 0, 0, 0, 0, 1, 0, 1);
        drive(0, 2, 999, 999, 0, 0, 1, 0);
        drive(1, 2, 100, 100, 0, 0, 0, 0);
        drive(0, 3, 100, 0, 100, 0, 1, 0);
        drive(0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 3),
                  $urandom_range(LINE-3, LINE+3) + (($urandom_range(0, 5) == 0) ? 400 : 0),
                  $urandom_range(LINE-3, LINE+3), $urandom_range(LINE-3, LINE+3),
                  $urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0,
                  $urandom_range(0, 3) == 0);
        end
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule